// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a set of SDRAM rows from power-on to normal operation without software. A one-cycle start pulse launches a fixed bring-up: a power-stable wait, a no-operation command, a precharge of all banks, eight auto-refresh commands and a mode-register load. After that the controller is placed in normal mode and periodic refresh is switched on. Every wait is a parameter counted in controller clocks.

Each command gets a window of `ROWS` consecutive slots, one slot per row. Slot r belongs to row r. A populated row receives the command with chip select low and its bit set in the one-hot row strobe. An empty row's slot stays deselected. The CAS latency select and the populated-row mask are captured at the start pulse, so the run's timing depends only on parameters. The mode word is built from the captured latency and the burst parameters, shifted left by three and driven on the address bus.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and until the first start: {cs_n,ras_n,cas_n,we_n} = 1111, address 0, row strobe 0, done 0, refresh enable 0, mode code 1.
- R2: The CAS latency select and the row mask are captured on the clock edge that samples start_i; later changes to them have no effect. A start pulse while a run is in progress, or after done, is ignored.
- R3: The first command slot begins PWR_WAIT clock cycles after the edge that samples start_i.
- R4: A command window is ROWS consecutive cycles, and slot r is for row r. A populated row gets the command with row_sel_o equal to 1<<r. An empty row's slot shows 1111 on the pins and row_sel_o = 0.
- R5: Command order and pin codes {cs_n,ras_n,cas_n,we_n}: no-op 0111 (address 0), then precharge-all 0010 (address with only bit 10 set), then exactly CBR_COUNT (default 8) auto-refresh commands 0001 (address 0), then mode-register load 0000.
- R6: The next window starts a fixed number of cycles after the last slot of the previous one: NOP_WAIT after no-op, TRP_WAIT after precharge, TRC_WAIT after each refresh and MRS_WAIT after the mode load.
- R7: The mode word has burst length in [2:0], burst type in [3], CAS code in [6:4] (010 for latency 2, 011 for latency 3), 00 in [8:7], write-burst mode in [9] and 00 in [11:10]. It is driven as address = word<<3. With the defaults (burst code 010, type 1, write mode 0) this is 0x1D0 for latency 3 and 0x150 for latency 2.
- R8: mode_o is 1 (no-op) from reset through the no-op wait. It is 2 from the first precharge slot, 4 from the first refresh slot, 3 from the mode-load slot, and 0 (normal) once done. Codes 5 to 7 never appear.
- R9: done_o and refresh_en_o both rise in the cycle after the mode-load wait ends. Neither is high earlier, both hold until reset, and no command is issued after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for the bring-up |
| cas3_i | input | 1 | 1 selects CAS latency 3, 0 selects latency 2 |
| row_pop_i | input | ROWS | Populated-row flags |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe pin, active low |
| cas_n_o | output | 1 | Column strobe pin, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Address bus (mode word, precharge-all bit) |
| row_sel_o | output | ROWS | One-hot strobe of the row being commanded |
| mode_o | output | 3 | Controller mode code |
| done_o | output | 1 | Bring-up complete |
| refresh_en_o | output | 1 | Periodic refresh enable |

## Verification
All outputs are decoded from state, so a result is visible in the cycle that follows the edge that changes the state. Counted from the edge that samples start, row r's no-op slot is due in cycle PWR_WAIT + r. Each later window is due ROWS plus the previous wait after the window before it, and done is due ROWS + MRS_WAIT cycles after the mode-load window opens. The driver computes every expected slot with its cycle stamp from these sums and queues it. The monitor samples on the falling edge and matches each asserted chip select against the head of the queue by cycle, pins, row strobe, address and mode. Expected slots that go unmatched, unexpected commands and early or late done are all reported.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    MODE_NORMAL = 3'd0,
    MODE_NOP    = 3'd1,
    MODE_PRE    = 3'd2,
    MODE_MRS    = 3'd3,
    MODE_CBR    = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_DONE
  } state_e;

  localparam logic [3:0] PINS_DESEL = 4'b1111;
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_PRE   = 4'b0010;
  localparam logic [3:0] PINS_CBR   = 4'b0001;
  localparam logic [3:0] PINS_MRS   = 4'b0000;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // [11:10]=0, [9]=write mode, [8:7]=0, [6:4]=latency, [3]=type, [2:0]=length
  function automatic logic [11:0] mode_word(input logic       cl3,
                                            input logic [2:0] blen,
                                            input logic       btype,
                                            input logic       wsingle);
    return {2'b00, wsingle, 2'b00, (cl3 ? 3'b011 : 3'b010), btype, blen};
  endfunction

endpackage

// File: rtl/sdram_init_wait_cnt.sv
module sdram_init_wait_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int         ROWS    = 8,
  parameter int         ADDR_W  = 15,
  parameter logic [2:0] BLEN    = 3'b010,
  parameter logic       BTYPE   = 1'b1,
  parameter logic       WSINGLE = 1'b0,
  localparam int        ROW_W   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              issue_i,
  input  mode_e             phase_i,
  input  logic [ROW_W-1:0]  row_idx_i,
  input  logic [ROWS-1:0]   row_pop_i,
  input  logic              cl3_i,
  output logic [3:0]        pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ROWS-1:0]   row_sel_o
);
  logic              hit;
  logic [ADDR_W-1:0] mrs_addr;

  assign hit      = issue_i && row_pop_i[row_idx_i];
  assign mrs_addr = ADDR_W'({mode_word(cl3_i, BLEN, BTYPE, WSINGLE), 3'b000});

  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_sel_o[r] = hit && (row_idx_i == ROW_W'(r));
    end
  end

  always_comb begin
    pins_o = PINS_DESEL;
    addr_o = '0;
    if (hit) begin
      case (phase_i)
        MODE_NOP: pins_o = PINS_NOP;
        MODE_PRE: begin
          pins_o = PINS_PRE;
          addr_o = ADDR_W'(1) << 10;
        end
        MODE_CBR: pins_o = PINS_CBR;
        MODE_MRS: begin
          pins_o = PINS_MRS;
          addr_o = mrs_addr;
        end
        default:  pins_o = PINS_DESEL;
      endcase
    end
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int         ROWS      = 8,
  parameter int         ADDR_W    = 15,
  parameter int         PWR_WAIT  = 13334,
  parameter int         NOP_WAIT  = 200,
  parameter int         TRP_WAIT  = 3,
  parameter int         TRC_WAIT  = 9,
  parameter int         MRS_WAIT  = 2,
  parameter int         CBR_COUNT = 8,
  parameter logic [2:0] BLEN      = 3'b010,
  parameter logic       BTYPE     = 1'b1,
  parameter logic       WSINGLE   = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cas3_i,
  input  logic [ROWS-1:0]   row_pop_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ROWS-1:0]   row_sel_o,
  output logic [2:0]        mode_o,
  output logic              done_o,
  output logic              refresh_en_o
);
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int MAX_WAIT = max2(max2(max2(PWR_WAIT, NOP_WAIT), max2(TRP_WAIT, TRC_WAIT)), MRS_WAIT);
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int CBR_W    = (CBR_COUNT > 1) ? $clog2(CBR_COUNT) : 1;

  state_e           state_q;
  mode_e            phase_q;
  logic             pwr_q;
  logic             refresh_q;
  logic             cl3_q;
  logic [ROWS-1:0]  pop_q;
  logic [ROW_W-1:0] row_idx_q;
  logic [CBR_W-1:0] cbr_left_q;
  logic             last_row;
  logic             wait_zero;
  logic             wait_load;
  logic [CNT_W-1:0] wait_val;
  logic [3:0]       pins;

  assign last_row = (row_idx_q == ROW_W'(ROWS - 1));

  always_comb begin
    wait_load = 1'b0;
    wait_val  = '0;
    if (state_q == ST_IDLE && start_i) begin
      wait_load = 1'b1;
      wait_val  = CNT_W'(PWR_WAIT - 1);
    end else if (state_q == ST_ISSUE && last_row) begin
      wait_load = 1'b1;
      case (phase_q)
        MODE_NOP: wait_val = CNT_W'(NOP_WAIT - 1);
        MODE_PRE: wait_val = CNT_W'(TRP_WAIT - 1);
        MODE_CBR: wait_val = CNT_W'(TRC_WAIT - 1);
        default:  wait_val = CNT_W'(MRS_WAIT - 1);
      endcase
    end
  end

  sdram_init_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wait_load),
    .load_val_i (wait_val),
    .zero_o     (wait_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= MODE_NOP;
      pwr_q      <= 1'b0;
      refresh_q  <= 1'b0;
      cl3_q      <= 1'b0;
      pop_q      <= '0;
      row_idx_q  <= '0;
      cbr_left_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          pwr_q   <= 1'b1;
          cl3_q   <= cas3_i;
          pop_q   <= row_pop_i;
        end
        ST_WAIT: if (wait_zero) begin
          row_idx_q <= '0;
          state_q   <= ST_ISSUE;
          if (pwr_q) begin
            pwr_q <= 1'b0;
          end else begin
            case (phase_q)
              MODE_NOP: phase_q <= MODE_PRE;
              MODE_PRE: begin
                phase_q    <= MODE_CBR;
                cbr_left_q <= CBR_W'(CBR_COUNT - 1);
              end
              MODE_CBR: begin
                if (cbr_left_q == '0) phase_q <= MODE_MRS;
                else                  cbr_left_q <= cbr_left_q - 1'b1;
              end
              default: begin
                state_q   <= ST_DONE;
                phase_q   <= MODE_NORMAL;
                refresh_q <= 1'b1;
              end
            endcase
          end
        end
        ST_ISSUE: begin
          row_idx_q <= row_idx_q + 1'b1;
          if (last_row) state_q <= ST_WAIT;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  sdram_init_cmd_enc #(
    .ROWS(ROWS), .ADDR_W(ADDR_W), .BLEN(BLEN), .BTYPE(BTYPE), .WSINGLE(WSINGLE)
  ) u_enc (
    .issue_i   (state_q == ST_ISSUE),
    .phase_i   (phase_q),
    .row_idx_i (row_idx_q),
    .row_pop_i (pop_q),
    .cl3_i     (cl3_q),
    .pins_o    (pins),
    .addr_o    (addr_o),
    .row_sel_o (row_sel_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins;
  assign mode_o       = phase_q;
  assign done_o       = (state_q == ST_DONE);
  assign refresh_en_o = refresh_q;
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [ROWS-1:0]   row_sel_o,
  input logic [2:0]        mode_o,
  input logic              done_o,
  input logic              refresh_en_o
);
  logic [3:0] pins;
  assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  p_sel_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_sel_o));

  p_sel_with_cs_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_sel_o != '0) |-> !cs_n_o);

  p_pre_a10_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0010) |-> (addr_o == (ADDR_W'(1) << 10)));

  p_mrs_word_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0000) |-> (addr_o == ADDR_W'(12'h1D0) || addr_o == ADDR_W'(12'h150)));

  p_cbr_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0001) |-> (mode_o == 3'd4));

  p_mode_legal_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd4);

  p_refresh_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_en_o |-> (done_o && mode_o == 3'd0));

  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_n_o && row_sel_o == '0));

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && refresh_en_o));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ROWS(ROWS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cs_n_o       (cs_n_o),
  .ras_n_o      (ras_n_o),
  .cas_n_o      (cas_n_o),
  .we_n_o       (we_n_o),
  .addr_o       (addr_o),
  .row_sel_o    (row_sel_o),
  .mode_o       (mode_o),
  .done_o       (done_o),
  .refresh_en_o (refresh_en_o)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS   = 4;
  localparam int ADDR_W = 15;
  localparam int PWR    = 20;
  localparam int NOPW   = 6;
  localparam int TRP    = 2;
  localparam int TRC    = 3;
  localparam int MRSW   = 2;
  localparam int NCBR   = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic              cas3_i = 1'b0;
  logic [ROWS-1:0]   row_pop_i = '0;
  logic              cs_n_o, ras_n_o, cas_n_o, we_n_o;
  logic [ADDR_W-1:0] addr_o;
  logic [ROWS-1:0]   row_sel_o;
  logic [2:0]        mode_o;
  logic              done_o, refresh_en_o;

  typedef struct {
    int              cyc;
    logic [3:0]      pins;
    logic [ROWS-1:0] sel;
    logic [ADDR_W-1:0] addr;
    logic [2:0]      mode;
    string           ttag;
    string           atag;
  } item_t;

  item_t sb_q[$];
  int ncount = 0;
  int done_at = -1;
  int checks = 0;
  int fails = 0;
  bit mon_en = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) ncount <= ncount + 1;

  sdram_init_seq #(
    .ROWS(ROWS), .ADDR_W(ADDR_W), .PWR_WAIT(PWR), .NOP_WAIT(NOPW),
    .TRP_WAIT(TRP), .TRC_WAIT(TRC), .MRS_WAIT(MRSW), .CBR_COUNT(NCBR)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cas3_i(cas3_i),
    .row_pop_i(row_pop_i), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
    .cas_n_o(cas_n_o), .we_n_o(we_n_o), .addr_o(addr_o),
    .row_sel_o(row_sel_o), .mode_o(mode_o), .done_o(done_o),
    .refresh_en_o(refresh_en_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, ncount);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // monitor: scoreboard compare on the falling edge
  always @(negedge clk_i) begin
    if (rst_ni && mon_en) begin
      automatic bit exp_done = (done_at >= 0) && (ncount >= done_at);
      chk(done_o == exp_done, "R9", "done_o", done_o, exp_done);
      chk(refresh_en_o == exp_done, "R9", "refresh_en_o", refresh_en_o, exp_done);
      if (done_at >= 0 && ncount == done_at)
        chk(mode_o == 3'd0, "R8", "mode at done", mode_o, 0);
      while (sb_q.size() > 0 && sb_q[0].cyc < ncount) begin
        chk(1'b0, sb_q[0].ttag, "missing command slot", ncount, sb_q[0].cyc);
        void'(sb_q.pop_front());
      end
      if (!cs_n_o) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected command", {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'hF);
        end else begin
          automatic item_t it = sb_q.pop_front();
          chk(it.cyc == ncount, it.ttag, "slot cycle", ncount, it.cyc);
          chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == it.pins, "R5", "pins",
              {cs_n_o, ras_n_o, cas_n_o, we_n_o}, it.pins);
          chk(row_sel_o == it.sel, "R4", "row_sel", row_sel_o, it.sel);
          chk(addr_o == it.addr, it.atag, "addr", addr_o, it.addr);
          chk(mode_o == it.mode, "R8", "mode", mode_o, it.mode);
        end
      end else if (row_sel_o != '0 || {ras_n_o, cas_n_o, we_n_o} != 3'b111) begin
        chk(1'b0, "R4", "empty slot not deselected", {row_sel_o, ras_n_o, cas_n_o, we_n_o}, 4'h7);
      end
    end
  end

  task automatic push_cmd(input int t, input logic [3:0] pins, input logic [ADDR_W-1:0] addr,
                          input logic [2:0] mode, input logic [ROWS-1:0] pop,
                          input string ttag, input string atag);
    for (int r = 0; r < ROWS; r++) begin
      if (pop[r]) begin
        automatic item_t it;
        it.cyc = t + r; it.pins = pins; it.sel = ROWS'(1) << r;
        it.addr = addr; it.mode = mode; it.ttag = ttag; it.atag = atag;
        sb_q.push_back(it);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    mon_en = 1'b0;
    rst_ni = 1'b0;
    start_i = 1'b0;
    done_at = -1;
    sb_q.delete();
    @(negedge clk_i);
    chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'hF, "R1", "pins in reset",
        {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'hF);
    chk(addr_o == '0 && row_sel_o == '0, "R1", "addr/sel in reset", {addr_o, row_sel_o}, 0);
    chk(!done_o && !refresh_en_o, "R1", "done/refresh in reset", {done_o, refresh_en_o}, 0);
    chk(mode_o == 3'd1, "R1", "mode in reset", mode_o, 1);
    rst_ni = 1'b1;
    mon_en = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic run_seq(input logic [ROWS-1:0] pop, input bit cl3, input bit poke);
    int t;
    int base;
    logic [ADDR_W-1:0] mrs;
    mrs = cl3 ? ADDR_W'(12'h1D0) : ADDR_W'(12'h150);
    @(negedge clk_i);
    start_i = 1'b1; cas3_i = cl3; row_pop_i = pop;
    @(negedge clk_i);
    start_i = 1'b0; base = ncount;
    cas3_i = !cl3; row_pop_i = ~pop;  // R2: late changes must not matter
    t = base + PWR;
    push_cmd(t, 4'b0111, '0, 3'd1, pop, "R3", "R5");
    t += ROWS + NOPW;
    push_cmd(t, 4'b0010, ADDR_W'(1) << 10, 3'd2, pop, "R6", "R5");
    t += ROWS + TRP;
    for (int i = 0; i < NCBR; i++) begin
      push_cmd(t, 4'b0001, '0, 3'd4, pop, "R6", "R5");
      t += ROWS + TRC;
    end
    push_cmd(t, 4'b0000, mrs, 3'd3, pop, "R6", "R7");
    t += ROWS + MRSW;
    done_at = t;
    if (poke) begin
      repeat (PWR + 3) @(negedge clk_i);
      start_i = 1'b1;  // R2: start during a run
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (ncount < done_at + 4) @(negedge clk_i);
    chk(sb_q.size() == 0, "R2", "pending commands after run", sb_q.size(), 0);
    chk(done_o && refresh_en_o, "R9", "done and refresh held", {done_o, refresh_en_o}, 3);
    if (poke) begin
      start_i = 1'b1;  // R2: start after done
      @(negedge clk_i);
      start_i = 1'b0;
      repeat (PWR + 2 * ROWS) @(negedge clk_i);
      chk(sb_q.size() == 0 && done_o, "R2", "start after done ignored", done_o, 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    do_reset();
    run_seq(4'b1111, 1'b1, 1'b0);
    do_reset();
    run_seq(4'b0101, 1'b0, 1'b1);
    do_reset();
    run_seq(4'b0000, 1'b1, 1'b0);
    do_reset();
    run_seq(4'b1000, 1'b0, 1'b1);
    do_reset();
    summary();
    $finish;
  end
endmodule